// File: doc/BRIEF.md
# Bit-Field Manipulation and Hash Unit

This execution unit runs the bit-level instructions that parsing and compression loops lean on. Each cycle it can accept an opcode and up to three 16-bit operands. It returns a 16-bit result and a zero flag one clock later, and both outputs come from a single output register stage. The operation set is:

- test, set and clear of one selected bit;
- extraction of a bit field, and merging of a field into a destination word;
- logical shifts and rotates in both directions;
- the position of the highest set bit;
- a short hash for indexing an associative table.

Instruction decode and the register file sit outside this block. A pipeline stage drives the opcode and operand bus, raises `in_valid`, and takes the registered result on the next clock. Widths, the hash output width and the hash multiplier are parameters. The barrel shifter and the field mask are generated from the data width.

Top module: `bitops_unit`

## Requirements
- R1: After reset, `out_valid`, `result` and `zero` are all 0.
- R2: When `in_valid` is high at a rising edge, `result` and `zero` for that operation appear after that edge and `out_valid` is 1. When `in_valid` is low at an edge, `out_valid` goes to 0 and `result` and `zero` keep their values.
- R3: Opcode 0 (test) returns bit `opa[opb[3:0]]` in `result[0]`, with the upper bits zero. Opcode 1 (set) returns `opa` with that bit forced to 1. Opcode 2 (clear) returns `opa` with that bit forced to 0.
- R4: Opcode 3 (extract) reads a start position from `opb[3:0]` and the length minus one from `opb[7:4]`. It returns `opa` bits from the start position upward, right-aligned, with zeros above the field. Field bits that would lie past bit 15 read as zero.
- R5: Opcode 4 (merge) takes the low field-length bits of `opa` and places them into `opc` at the start position, using the same field encoding as R4. All other bits of `opc` pass through unchanged, and field bits past bit 15 are dropped.
- R6: Opcode 5 shifts `opa` left logically and opcode 6 shifts it right logically. In both cases the shift amount is `opb[3:0]` and the vacated bits are filled with zeros.
- R7: Opcode 7 rotates `opa` left and opcode 8 rotates it right, by `opb[3:0]` places.
- R8: Opcode 9 returns the bit index (0 to 15) of the highest set bit of a nonzero `opa`, with `zero` = 0.
- R9: Opcode 9 with `opa` = 0 returns all ones with `zero` = 1.
- R10: Opcode 10 (hash) forms `opa[15:8] ^ opa[7:0]` and multiplies it by `HASH_MULT` modulo 2^16. It returns the low `HASH_W` bits of that product, zero-extended.
- R11: For every opcode other than 9, `zero` is 1 exactly when `result` is 0.
- R12: Opcodes 11 to 15 return 0 with `zero` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are sampled this cycle |
| op | input | 4 | Operation code |
| opa | input | 16 | Source word |
| opb | input | 16 | Bit index, shift amount or field descriptor |
| opc | input | 16 | Destination word for merge |
| out_valid | output | 1 | Result register was loaded at the last edge |
| result | output | 16 | Registered result |
| zero | output | 1 | Registered zero flag |

## Verification
The block keeps almost no state: it has only the output register and the valid bit. A corrupted field mask, a wrong shifter stage or a bad priority scan therefore shows up in `result` on the very next cycle, but only for the opcode and operand values that exercise the broken path. For that reason the bench sweeps every bit index, every shift amount and every start and length pair against several operand patterns. A hold fault or a stuck valid bit shows on the first idle cycle, when `result` changes or `out_valid` stays high. A zero-flag fault shows on the first zero or nonzero result of the opcodes it affects.

// File: rtl/bitops_pkg.sv
package bitops_pkg;
   typedef enum logic [3:0] {
      OP_BTST = 4'd0,
      OP_BSET = 4'd1,
      OP_BCLR = 4'd2,
      OP_FEXT = 4'd3,
      OP_FMRG = 4'd4,
      OP_SHL  = 4'd5,
      OP_SHR  = 4'd6,
      OP_ROL  = 4'd7,
      OP_ROR  = 4'd8,
      OP_MSB  = 4'd9,
      OP_HASH = 4'd10
   } bitop_e;
endpackage

// File: rtl/bitops_field.sv
module bitops_field #(
   parameter int DATA_W = 16,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] src,
   input  logic [POS_W-1:0]  pos,
   input  logic [POS_W-1:0]  lenm1,
   input  logic [DATA_W-1:0] dst,
   output logic [DATA_W-1:0] res
);
   import bitops_pkg::*;

   logic [DATA_W-1:0] len_mask;
   logic [DATA_W-1:0] place_mask;
   logic [DATA_W-1:0] one_hot;

   // one mask bit per data bit: set while below the field length
   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign len_mask[i] = (POS_W'(i) <= lenm1);
   end

   assign place_mask = len_mask << pos;
   assign one_hot    = DATA_W'(1) << pos;

   always_comb begin
      unique case (op)
         OP_BTST: res = DATA_W'((src & one_hot) != '0);
         OP_BSET: res = src | one_hot;
         OP_BCLR: res = src & ~one_hot;
         OP_FEXT: res = (src >> pos) & len_mask;
         OP_FMRG: res = (dst & ~place_mask) | ((src & len_mask) << pos);
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/bitops_shift.sv
module bitops_shift #(
   parameter int DATA_W = 16,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] src,
   input  logic [AMT_W-1:0]  amt,
   input  logic              left,
   input  logic              rotate,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] stg [0:AMT_W];
   logic [DATA_W-1:0] src_rev;
   logic [DATA_W-1:0] out_rev;

   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign src_rev[i] = src[DATA_W-1-i];
      assign out_rev[i] = stg[AMT_W][DATA_W-1-i];
   end

   // left-direction work runs the right shifter on the mirrored word
   assign stg[0] = left ? src_rev : src;

   for (genvar k = 0; k < AMT_W; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [S-1:0] fill;
      assign fill = rotate ? stg[k][S-1:0] : '0;
      assign stg[k+1] = amt[k] ? {fill, stg[k][DATA_W-1:S]} : stg[k];
   end

   assign res = left ? out_rev : stg[AMT_W];
endmodule

// File: rtl/bitops_scan.sv
module bitops_scan #(
   parameter int DATA_W    = 16,
   parameter int HASH_W    = 10,
   parameter logic [DATA_W-1:0] HASH_MULT = 16'h9E37,
   localparam int HALF_W = DATA_W / 2
) (
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] msb_idx,
   output logic [DATA_W-1:0] hash
);
   logic [HALF_W-1:0] folded;
   logic [DATA_W-1:0] product;

   always_comb begin
      msb_idx = '1;
      for (int i = 0; i < DATA_W; i++) begin
         if (src[i]) msb_idx = DATA_W'(i);
      end
   end

   assign folded  = src[DATA_W-1:HALF_W] ^ src[HALF_W-1:0];
   assign product = DATA_W'(folded) * HASH_MULT;

   if (HASH_W == DATA_W) begin : g_hash_full
      assign hash = product;
   end else begin : g_hash_part
      assign hash = {{(DATA_W-HASH_W){1'b0}}, product[HASH_W-1:0]};
   end
endmodule

// File: rtl/bitops_unit.sv
module bitops_unit #(
   parameter int DATA_W    = 16,
   parameter int HASH_W    = 10,
   parameter logic [DATA_W-1:0] HASH_MULT = 16'h9E37,
   localparam int POS_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] opc,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic              zero
);
   import bitops_pkg::*;

   if ((1 << POS_W) != DATA_W || DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 8");
   end
   if (HASH_W < 1 || HASH_W > DATA_W) begin : g_bad_hash
      $error("HASH_W must lie in 1..DATA_W");
   end
   if (HASH_MULT[0] != 1'b1) begin : g_bad_mult
      $error("HASH_MULT must be odd");
   end

   logic [DATA_W-1:0] fld_res, sh_res, msb_res, hash_res;
   logic [DATA_W-1:0] res_d;
   logic              zero_d;
   logic              sh_left, sh_rot;

   bitops_field #(.DATA_W(DATA_W)) u_field (
      .op(op), .src(opa), .pos(opb[POS_W-1:0]),
      .lenm1(opb[2*POS_W-1:POS_W]), .dst(opc), .res(fld_res)
   );

   assign sh_left = (op == OP_SHL) || (op == OP_ROL);
   assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

   bitops_shift #(.DATA_W(DATA_W)) u_shift (
      .src(opa), .amt(opb[POS_W-1:0]), .left(sh_left),
      .rotate(sh_rot), .res(sh_res)
   );

   bitops_scan #(.DATA_W(DATA_W), .HASH_W(HASH_W), .HASH_MULT(HASH_MULT)) u_scan (
      .src(opa), .msb_idx(msb_res), .hash(hash_res)
   );

   always_comb begin
      unique case (op)
         OP_BTST, OP_BSET, OP_BCLR, OP_FEXT, OP_FMRG: res_d = fld_res;
         OP_SHL, OP_SHR, OP_ROL, OP_ROR:              res_d = sh_res;
         OP_MSB:                                      res_d = msb_res;
         OP_HASH:                                     res_d = hash_res;
         default:                                     res_d = '0;
      endcase
      zero_d = (op == OP_MSB) ? (opa == '0) : (res_d == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         zero      <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result <= res_d;
            zero   <= zero_d;
         end
      end
   end

   // R2
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result) && $stable(zero)));
   // R9
   msb_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_MSB && opa == '0) |=> (result == '1 && zero));
   // R4
   fext_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == OP_FEXT) |=>
         ((result >> ({1'b0, $past(opb[2*POS_W-1:POS_W])} + 1'b1)) == '0));
   // R11
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op != OP_MSB) |=> (zero == (result == '0)));

   if (HASH_W < DATA_W) begin : g_hash_chk
      // R10
      hash_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == OP_HASH) |=> (result[DATA_W-1:HASH_W] == '0));
   end
endmodule

// File: tb/sim_bitops_unit.sv
`timescale 1ns/1ps
module sim_bitops_unit;
   localparam int W = 16;
   localparam int HW = 10;
   localparam logic [15:0] MULT = 16'h9E37;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [3:0] op = '0;
   logic [15:0] opa = '0, opb = '0, opc = '0;
   logic out_valid, zero;
   logic [15:0] result;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   bitops_unit #(.DATA_W(W), .HASH_W(HW), .HASH_MULT(MULT)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opa(opa), .opb(opb), .opc(opc),
      .out_valid(out_valid), .result(result), .zero(zero)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp,
                      input logic gz, input logic ez);
      checks++;
      if (got !== exp || gz !== ez) begin
         fails++;
         $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b", tag, got, gz, exp, ez);
      end
   endtask

   task automatic run(input string tag, input logic [3:0] o, input logic [15:0] a,
                      input logic [15:0] b, input logic [15:0] c,
                      input logic [15:0] er, input logic ez);
      @(negedge clk);
      in_valid = 1'b1; op = o; opa = a; opb = b; opc = c;
      @(negedge clk);
      in_valid = 1'b0;
      chk(tag, result, er, zero, ez);
      checks++;
      if (out_valid !== 1'b1) begin
         fails++;
         $display("FAIL R2: out_valid=%b expected 1", out_valid);
      end
   endtask

   function automatic logic [15:0] fmask(input int len);
      return 16'(((1 << len) - 1) & 32'hFFFF);
   endfunction

   initial begin
      logic [15:0] pats [6];
      logic [15:0] er;
      pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
      pats[3] = 16'h1234; pats[4] = 16'h8001; pats[5] = 16'h7E18;

      #1;
      // R1 reset state
      chk("R1", result, 16'h0, zero, 1'b0);
      checks++;
      if (out_valid !== 1'b0) begin fails++; $display("FAIL R1: out_valid=%b expected 0", out_valid); end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3 single-bit test/set/clear
      for (int p = 0; p < 6; p++)
         for (int i = 0; i < 16; i++) begin
            er = {15'b0, pats[p][i]};
            run("R3 test", 4'd0, pats[p], 16'(i), 16'h0, er, er == 0);
            er = pats[p] | 16'(1 << i);
            run("R3 set", 4'd1, pats[p], 16'(i), 16'h0, er, er == 0);
            er = pats[p] & ~16'(1 << i);
            run("R3 clear", 4'd2, pats[p], 16'(i), 16'h0, er, er == 0);
         end

      // R4 / R5 field extract and merge, all start/length pairs
      for (int p = 1; p < 6; p++)
         for (int pos = 0; pos < 16; pos++)
            for (int l = 1; l <= 16; l++) begin
               er = (pats[p] >> pos) & fmask(l);
               run("R4 extract", 4'd3, pats[p], 16'((l - 1) * 16 + pos), 16'h0, er, er == 0);
               er = 16'((({16'h0, pats[(p + 2) % 6]} & ~({16'h0, fmask(l)} << pos)) |
                        (({16'h0, pats[p] & fmask(l)}) << pos)) & 32'hFFFF);
               run("R5 merge", 4'd4, pats[p], 16'((l - 1) * 16 + pos), pats[(p + 2) % 6], er, er == 0);
            end

      // R6 / R7 shifts and rotates
      for (int p = 1; p < 6; p++)
         for (int s = 0; s < 16; s++) begin
            er = 16'(({16'h0, pats[p]} << s) & 32'hFFFF);
            run("R6 shl", 4'd5, pats[p], 16'(s), 16'h0, er, er == 0);
            er = pats[p] >> s;
            run("R6 shr", 4'd6, pats[p], 16'(s), 16'h0, er, er == 0);
            er = 16'(((({16'h0, pats[p]} << s) | ({16'h0, pats[p]} >> (16 - s)))) & 32'hFFFF);
            run("R7 rol", 4'd7, pats[p], 16'(s), 16'h0, er, er == 0);
            er = 16'(((({16'h0, pats[p]} >> s) | ({16'h0, pats[p]} << (16 - s)))) & 32'hFFFF);
            run("R7 ror", 4'd8, pats[p], 16'(s), 16'h0, er, er == 0);
         end

      // R8 MSB index, single bits and bits with lower noise
      for (int i = 0; i < 16; i++) begin
         run("R8 msb", 4'd9, 16'(1 << i), 16'h0, 16'h0, 16'(i), 1'b0);
         run("R8 msb", 4'd9, 16'(1 << i) | (16'h5555 & 16'((1 << i) - 1)), 16'h0, 16'h0, 16'(i), 1'b0);
      end
      // R9 zero input
      run("R9 msb zero", 4'd9, 16'h0, 16'h0, 16'h0, 16'hFFFF, 1'b1);

      // R10 hash, sweep of 1024 words
      for (int n = 0; n < 1024; n++) begin
         logic [15:0] a;
         a = 16'((n * 40503 + 7) & 16'hFFFF);
         er = 16'((32'(a[15:8] ^ a[7:0]) * 32'(MULT)) % (1 << HW));
         run("R10 hash", 4'd10, a, 16'h0, 16'h0, er, er == 0);
      end

      // R11 zero flag on zero result from a nonzero-input op
      run("R11 zero", 4'd2, 16'h0100, 16'h0008, 16'h0, 16'h0, 1'b1);
      run("R11 nonzero", 4'd6, 16'h8000, 16'h000F, 16'h0, 16'h0001, 1'b0);

      // R12 unused opcodes
      for (int o = 11; o < 16; o++)
         run("R12 unused", 4'(o), 16'hBEEF, 16'h1234, 16'h5678, 16'h0, 1'b1);

      // R2 hold: idle cycle with new operands
      run("R2 load", 4'd5, 16'h0003, 16'h0004, 16'h0, 16'h0030, 1'b0);
      @(negedge clk);
      op = 4'd1; opa = 16'hFFFF; opb = 16'h0; in_valid = 1'b0;
      @(negedge clk);
      chk("R2 hold", result, 16'h0030, zero, 1'b0);
      checks++;
      if (out_valid !== 1'b0) begin fails++; $display("FAIL R2: out_valid=%b expected 0", out_valid); end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule